// File: doc/BRIEF.md
# Windowed Address Translator

This block translates request addresses through a small set of programmable windows. There are two directions, inbound and outbound, and each direction has `NUM_WIN` windows. All windows are programmed through one shared group of 32-bit registers. A viewport register picks which window that group currently reads and writes.

Each window holds the following fields:

- a 64-bit base
- a 32-bit upper bound (the limit)
- a 64-bit target
- a type word
- a control word whose top bit enables the window

Programming a window does not change translation right away. A window's settings take effect only at the moment its control word is written. Software can therefore rewrite base, limit and target freely and then commit them with a single write.

Outbound requests are matched against enabled outbound windows, and inbound requests against enabled inbound windows. A memory-type hit produces target plus the offset into the window. An outbound hit on a configuration-type window produces a configuration access instead: a bus number, a device/function number and a register offset, all taken from the window. Inbound requests that match nothing pass through unchanged. Outbound requests that match nothing are flagged as unmapped.

Top module: `atu_viewport`

## Requirements
- R1: The register at offset 0x900 selects a window. Bits 3:0 give the index and bit 31 set means inbound. All 32 bits read back as written. The selected window's fields sit at these offsets: 0x904 type word, 0x908 control word, 0x90C base bits 31:0, 0x910 base bits 63:32, 0x914 limit, 0x918 target bits 31:0, 0x91C target bits 63:32. Each field reads back what was last written to it.
- R2: A selected index of `NUM_WIN` or more drops window writes and reads as 0. Any offset not listed in R1 reads 0 and ignores writes.
- R3: After reset, every window has base 0, target 0, limit 0xFFFFFFFF, type word 0 and control word 0. The one exception is inbound window 0, whose control word is 0x80000000 and which is active from reset. The viewport register resets to 0 and all outputs reset to 0.
- R4: Translation uses a copy of a window's fields taken when its control word is written. Bit 31 of that write is the enable. Writes to the other fields change no translation until the next control-word write.
- R5: A request hits a window when base <= address <= {base[63:32], limit}, compared as 64-bit values.
- R6: On a memory-type hit, the output address is target + (address - base), modulo 2^64.
- R7: An outbound window whose committed type word was nonzero is a configuration window. A hit on it sets `ob_cfg`, drives `ob_xaddr` to 0, and outputs bus = target[31:24], devfn = target[23:16] and offset = (address - base)[CFG_OFF_W-1:0]. On every other result, `ob_bus`, `ob_devfn` and `ob_cfg_off` are 0.
- R8: When several enabled windows of one direction hit, the lowest index wins.
- R9: An inbound miss outputs the input address with `ib_hit` low. An outbound miss outputs the input address with `ob_miss` high and `ob_hit` low.
- R10: Inbound windows are always memory type, whatever their type word holds.
- R11: Results are registered. Outputs appear one cycle after the request, and valid is the request delayed by one cycle. A request in the same cycle as a control-word write uses the mapping in force before that write.
- R12: Outbound windows never affect inbound results, and inbound windows never affect outbound results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| ob_req | input | 1 | Outbound request valid |
| ob_addr | input | 64 | Outbound request address |
| ob_vld | output | 1 | Outbound result valid |
| ob_hit | output | 1 | Outbound window hit |
| ob_miss | output | 1 | Outbound request unmapped |
| ob_cfg | output | 1 | Outbound hit is a configuration access |
| ob_xaddr | output | 64 | Translated outbound address |
| ob_bus | output | 8 | Configuration bus number |
| ob_devfn | output | 8 | Configuration device/function number |
| ob_cfg_off | output | CFG_OFF_W | Configuration register offset |
| ib_req | input | 1 | Inbound request valid |
| ib_addr | input | 64 | Inbound request address |
| ib_vld | output | 1 | Inbound result valid |
| ib_hit | output | 1 | Inbound window hit |
| ib_xaddr | output | 64 | Translated or passed-through inbound address |

## Verification
The bench builds the block with `NUM_WIN` = 3 and `CFG_OFF_W` = 12. The odd window count leaves indices 3 to 15 out of range, which exercises the dropped writes and zero reads of R2. It also makes the inbound slot arithmetic land off a power of two. With only three windows per direction, randomly placed windows in a narrow address span overlap often, so the priority of R8 and the commit-only behaviour of R4 are hit many times during the random phase. A 12-bit offset covers a full configuration space.

// File: rtl/atu_viewport.sv
module atu_viewport #(
  parameter int NUM_WIN   = 4,
  parameter int CFG_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 ob_req,
  input  logic [63:0]          ob_addr,
  output logic                 ob_vld,
  output logic                 ob_hit,
  output logic                 ob_miss,
  output logic                 ob_cfg,
  output logic [63:0]          ob_xaddr,
  output logic [7:0]           ob_bus,
  output logic [7:0]           ob_devfn,
  output logic [CFG_OFF_W-1:0] ob_cfg_off,
  input  logic                 ib_req,
  input  logic [63:0]          ib_addr,
  output logic                 ib_vld,
  output logic                 ib_hit,
  output logic [63:0]          ib_xaddr
);

  localparam int NS = 2 * NUM_WIN;
  localparam int SW = $clog2(NS);
  localparam logic [11:0] OFF_VP  = 12'h900;
  localparam logic [11:0] OFF_TY  = 12'h904;
  localparam logic [11:0] OFF_CT  = 12'h908;
  localparam logic [11:0] OFF_BLO = 12'h90C;
  localparam logic [11:0] OFF_BHI = 12'h910;
  localparam logic [11:0] OFF_LIM = 12'h914;
  localparam logic [11:0] OFF_TLO = 12'h918;
  localparam logic [11:0] OFF_THI = 12'h91C;

  logic [31:0] vp_q;
  logic [63:0] base_q [NS];
  logic [63:0] tgt_q  [NS];
  logic [31:0] lim_q  [NS];
  logic [31:0] ty_q   [NS];
  logic [31:0] ct_q   [NS];

  logic [NS-1:0] a_en, a_cfg;
  logic [63:0]   a_base [NS];
  logic [63:0]   a_tgt  [NS];
  logic [31:0]   a_lim  [NS];

  logic          sel_ok;
  logic [SW-1:0] sel_slot;
  logic          ct_wr;

  assign sel_ok   = {1'b0, vp_q[3:0]} < 5'(NUM_WIN);
  assign sel_slot = vp_q[31] ? SW'(NUM_WIN + int'(vp_q[3:0])) : SW'(vp_q[3:0]);
  assign ct_wr    = reg_we && sel_ok && (reg_addr == OFF_CT);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_VP) reg_rdata = vp_q;
    else if (sel_ok) begin
      case (reg_addr)
        OFF_TY:  reg_rdata = ty_q[sel_slot];
        OFF_CT:  reg_rdata = ct_q[sel_slot];
        OFF_BLO: reg_rdata = base_q[sel_slot][31:0];
        OFF_BHI: reg_rdata = base_q[sel_slot][63:32];
        OFF_LIM: reg_rdata = lim_q[sel_slot];
        OFF_TLO: reg_rdata = tgt_q[sel_slot][31:0];
        OFF_THI: reg_rdata = tgt_q[sel_slot][63:32];
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_q <= '0;
      for (int s = 0; s < NS; s++) begin
        base_q[s] <= '0;
        tgt_q[s]  <= '0;
        lim_q[s]  <= '1;
        ty_q[s]   <= '0;
        ct_q[s]   <= (s == NUM_WIN) ? 32'h8000_0000 : 32'h0;
        a_en[s]   <= (s == NUM_WIN);
        a_cfg[s]  <= 1'b0;
        a_base[s] <= '0;
        a_tgt[s]  <= '0;
        a_lim[s]  <= '1;
      end
    end else if (reg_we) begin
      if (reg_addr == OFF_VP) vp_q <= reg_wdata;
      for (int s = 0; s < NS; s++) begin
        if (sel_ok && sel_slot == SW'(s)) begin
          case (reg_addr)
            OFF_TY:  ty_q[s] <= reg_wdata;
            OFF_BLO: base_q[s][31:0]  <= reg_wdata;
            OFF_BHI: base_q[s][63:32] <= reg_wdata;
            OFF_LIM: lim_q[s] <= reg_wdata;
            OFF_TLO: tgt_q[s][31:0]  <= reg_wdata;
            OFF_THI: tgt_q[s][63:32] <= reg_wdata;
            OFF_CT: begin
              ct_q[s]   <= reg_wdata;
              a_en[s]   <= reg_wdata[31];
              a_cfg[s]  <= (s < NUM_WIN) && (ty_q[s] != 32'h0);
              a_base[s] <= base_q[s];
              a_tgt[s]  <= tgt_q[s];
              a_lim[s]  <= lim_q[s];
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic          ob_h, ib_h;
  logic [SW-1:0] ob_s, ib_s;
  logic [63:0]   ob_off, ib_off;

  always_comb begin
    ob_h = 1'b0;
    ob_s = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (a_en[i] && ob_addr >= a_base[i] && ob_addr <= {a_base[i][63:32], a_lim[i]}) begin
        ob_h = 1'b1;
        ob_s = SW'(i);
      end
    end
  end

  always_comb begin
    ib_h = 1'b0;
    ib_s = SW'(NUM_WIN);
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (a_en[NUM_WIN+i] && ib_addr >= a_base[NUM_WIN+i] &&
          ib_addr <= {a_base[NUM_WIN+i][63:32], a_lim[NUM_WIN+i]}) begin
        ib_h = 1'b1;
        ib_s = SW'(NUM_WIN + i);
      end
    end
  end

  assign ob_off = ob_addr - a_base[ob_s];
  assign ib_off = ib_addr - a_base[ib_s];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_vld <= 1'b0; ob_hit <= 1'b0; ob_miss <= 1'b0; ob_cfg <= 1'b0;
      ob_xaddr <= '0; ob_bus <= '0; ob_devfn <= '0; ob_cfg_off <= '0;
      ib_vld <= 1'b0; ib_hit <= 1'b0; ib_xaddr <= '0;
    end else begin
      ob_vld  <= ob_req;
      ob_hit  <= ob_req && ob_h;
      ob_miss <= ob_req && !ob_h;
      ob_cfg  <= ob_req && ob_h && a_cfg[ob_s];
      if (!ob_h) begin
        ob_xaddr <= ob_addr; ob_bus <= '0; ob_devfn <= '0; ob_cfg_off <= '0;
      end else if (a_cfg[ob_s]) begin
        ob_xaddr   <= '0;
        ob_bus     <= a_tgt[ob_s][31:24];
        ob_devfn   <= a_tgt[ob_s][23:16];
        ob_cfg_off <= ob_off[CFG_OFF_W-1:0];
      end else begin
        ob_xaddr <= a_tgt[ob_s] + ob_off; ob_bus <= '0; ob_devfn <= '0; ob_cfg_off <= '0;
      end
      ib_vld   <= ib_req;
      ib_hit   <= ib_req && ib_h;
      ib_xaddr <= ib_h ? a_tgt[ib_s] + ib_off : ib_addr;
    end
  end

  p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_req && ib_req) |=> (ob_vld && ib_vld));
  p_vld_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ob_req && !ib_req) |=> (!ob_vld && !ib_vld));
  p_cfg_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ob_cfg |-> (ob_hit && ob_xaddr == 64'h0));
  p_hit_miss_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ob_vld |-> (ob_hit != ob_miss));
  p_ib_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |=> (ib_hit || ib_xaddr == $past(ib_addr)));
  p_ob_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ob_req |=> (!ob_miss || ob_xaddr == $past(ob_addr)));
  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ct_wr |=> $stable(a_en));

endmodule

// File: tb/atu_viewport_test.sv
module atu_viewport_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;
  localparam int OW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ob_req = 1'b0, ib_req = 1'b0;
  logic [63:0] ob_addr = '0, ib_addr = '0;
  logic ob_vld, ob_hit, ob_miss, ob_cfg, ib_vld, ib_hit;
  logic [63:0] ob_xaddr, ib_xaddr;
  logic [7:0] ob_bus, ob_devfn;
  logic [OW-1:0] ob_cfg_off;

  atu_viewport #(.NUM_WIN(NW), .CFG_OFF_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_req(ob_req), .ob_addr(ob_addr), .ob_vld(ob_vld), .ob_hit(ob_hit),
    .ob_miss(ob_miss), .ob_cfg(ob_cfg), .ob_xaddr(ob_xaddr), .ob_bus(ob_bus),
    .ob_devfn(ob_devfn), .ob_cfg_off(ob_cfg_off),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_vld(ib_vld), .ib_hit(ib_hit),
    .ib_xaddr(ib_xaddr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R3";

  // reference state: slot = dir*NW + index
  logic [31:0] m_vp;
  logic [63:0] m_base [2*NW], m_tgt [2*NW], m_abase [2*NW], m_atgt [2*NW];
  logic [31:0] m_lim [2*NW], m_ty [2*NW], m_ct [2*NW], m_alim [2*NW];
  bit m_aen [2*NW], m_acfg [2*NW];
  logic e_ob_vld, e_ob_hit, e_ob_miss, e_ob_cfg, e_ib_vld, e_ib_hit;
  logic [63:0] e_ob_xaddr, e_ib_xaddr;
  logic [7:0] e_ob_bus, e_ob_devfn;
  logic [OW-1:0] e_ob_off;

  function automatic int mfind(input int dir, input logic [63:0] a);
    for (int i = 0; i < NW; i++) begin
      int s;
      s = dir * NW + i;
      if (m_aen[s] && a >= m_abase[s] && a <= {m_abase[s][63:32], m_alim[s]}) return s;
    end
    return -1;
  endfunction

  function automatic int msel();
    if (int'(m_vp[3:0]) >= NW) return -1;
    return (m_vp[31] ? NW : 0) + int'(m_vp[3:0]);
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    int s;
    s = msel();
    if (a == 12'h900) return m_vp;
    if (s < 0) return 32'h0;
    case (a)
      12'h904: return m_ty[s];
      12'h908: return m_ct[s];
      12'h90C: return m_base[s][31:0];
      12'h910: return m_base[s][63:32];
      12'h914: return m_lim[s];
      12'h918: return m_tgt[s][31:0];
      12'h91C: return m_tgt[s][63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vp = 0;
      for (int s = 0; s < 2*NW; s++) begin
        m_base[s] = 0; m_tgt[s] = 0; m_lim[s] = 32'hFFFF_FFFF; m_ty[s] = 0;
        m_ct[s] = (s == NW) ? 32'h8000_0000 : 0;
        m_aen[s] = (s == NW); m_acfg[s] = 0;
        m_abase[s] = 0; m_atgt[s] = 0; m_alim[s] = 32'hFFFF_FFFF;
      end
      e_ob_vld = 0; e_ob_hit = 0; e_ob_miss = 0; e_ob_cfg = 0; e_ob_xaddr = 0;
      e_ob_bus = 0; e_ob_devfn = 0; e_ob_off = 0;
      e_ib_vld = 0; e_ib_hit = 0; e_ib_xaddr = 0;
    end else begin
      int os, is, s;
      logic [63:0] d;
      os = mfind(0, ob_addr);
      is = mfind(1, ib_addr);
      e_ob_vld = ob_req; e_ob_hit = ob_req && os >= 0; e_ob_miss = ob_req && os < 0;
      e_ob_cfg = 0; e_ob_bus = 0; e_ob_devfn = 0; e_ob_off = 0;
      if (os < 0) e_ob_xaddr = ob_addr;
      else begin
        d = ob_addr - m_abase[os];
        if (m_acfg[os]) begin
          e_ob_cfg = ob_req; e_ob_xaddr = 0;
          e_ob_bus = m_atgt[os][31:24]; e_ob_devfn = m_atgt[os][23:16]; e_ob_off = d[OW-1:0];
        end else e_ob_xaddr = m_atgt[os] + d;
      end
      e_ib_vld = ib_req; e_ib_hit = ib_req && is >= 0;
      e_ib_xaddr = (is < 0) ? ib_addr : m_atgt[is] + (ib_addr - m_abase[is]);
      if (reg_we) begin
        s = msel();
        if (reg_addr == 12'h900) m_vp = reg_wdata;
        else if (s >= 0) begin
          case (reg_addr)
            12'h904: m_ty[s] = reg_wdata;
            12'h90C: m_base[s][31:0] = reg_wdata;
            12'h910: m_base[s][63:32] = reg_wdata;
            12'h914: m_lim[s] = reg_wdata;
            12'h918: m_tgt[s][31:0] = reg_wdata;
            12'h91C: m_tgt[s][63:32] = reg_wdata;
            12'h908: begin
              m_ct[s] = reg_wdata; m_aen[s] = reg_wdata[31];
              m_acfg[s] = (s < NW) && (m_ty[s] != 0);
              m_abase[s] = m_base[s]; m_atgt[s] = m_tgt[s]; m_alim[s] = m_lim[s];
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("reg_rdata", 64'(reg_rdata), 64'(mread(reg_addr)));
    chk("ob_vld", 64'(ob_vld), 64'(e_ob_vld));
    chk("ob_hit", 64'(ob_hit), 64'(e_ob_hit));
    chk("ob_miss", 64'(ob_miss), 64'(e_ob_miss));
    chk("ob_cfg", 64'(ob_cfg), 64'(e_ob_cfg));
    chk("ob_xaddr", ob_xaddr, e_ob_xaddr);
    chk("ob_bus", 64'(ob_bus), 64'(e_ob_bus));
    chk("ob_devfn", 64'(ob_devfn), 64'(e_ob_devfn));
    chk("ob_cfg_off", 64'(ob_cfg_off), 64'(e_ob_off));
    chk("ib_vld", 64'(ib_vld), 64'(e_ib_vld));
    chk("ib_hit", 64'(ib_hit), 64'(e_ib_hit));
    chk("ib_xaddr", ib_xaddr, e_ib_xaddr);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    reg_we = 1; reg_addr = a; reg_wdata = v; tick(); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    reg_addr = a; tick();
  endtask

  task automatic obq(input logic [63:0] a);
    ob_req = 1; ob_addr = a; tick(); ob_req = 0;
  endtask

  task automatic ibq(input logic [63:0] a);
    ib_req = 1; ib_addr = a; tick(); ib_req = 0;
  endtask

  task automatic prog(input logic [31:0] vp, input logic [63:0] b, input logic [31:0] l,
                      input logic [63:0] t, input logic [31:0] ty);
    wr(12'h900, vp); wr(12'h90C, b[31:0]); wr(12'h910, b[63:32]); wr(12'h914, l);
    wr(12'h918, t[31:0]); wr(12'h91C, t[63:32]); wr(12'h904, ty);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R3: reset state
    cur_req = "R3";
    tick(); tick(); tick();
    rst_n = 1;
    rd(12'h914); rd(12'h908);
    wr(12'h900, 32'h8000_0000); rd(12'h908); rd(12'h914); rd(12'h90C);
    // R10 R9: inbound window 0 passes everything below 4G, misses above
    cur_req = "R9";
    ibq(64'h1234); ibq(64'h1_0000_0000);
    obq(64'h5000);
    // R1: programming and readback of outbound window 1
    cur_req = "R1";
    prog(32'h1, 64'h1000, 32'h1FFF, 64'h2_ABC0_0000, 32'h0);
    rd(12'h900); rd(12'h904); rd(12'h90C); rd(12'h910); rd(12'h914); rd(12'h918); rd(12'h91C);
    // R4: nothing takes effect until the control word is written
    cur_req = "R4";
    obq(64'h1800);
    wr(12'h908, 32'h8000_0000);
    cur_req = "R6";
    obq(64'h1800); obq(64'h1234);
    cur_req = "R4";
    wr(12'h90C, 32'h3000); obq(64'h1800); rd(12'h90C);
    // R5: window edges
    cur_req = "R5";
    obq(64'h1000); obq(64'h0FFF); obq(64'h1FFF); obq(64'h2000);
    // R8: overlapping window 0 beats window 1
    cur_req = "R8";
    prog(32'h0, 64'h1800, 32'h1FFF, 64'h9000_0000, 32'h0);
    wr(12'h908, 32'h8000_0000);
    obq(64'h1900); obq(64'h1100);
    // R7: configuration window
    cur_req = "R7";
    prog(32'h2, 64'h4000_0000, 32'h4000_FFFF, 64'h1234_0000, 32'h4);
    wr(12'h908, 32'h8000_0000);
    obq(64'h4000_0ABC); obq(64'h4000_FFFF);
    // R10: inbound with nonzero type word stays memory type
    cur_req = "R10";
    prog(32'h8000_0001, 64'h1_0000_0000, 32'h0FFF, 64'h7000, 32'h4);
    wr(12'h908, 32'h8000_0000);
    ibq(64'h1_0000_0010); ibq(64'h20);
    // R12: outbound view unaffected by inbound window
    cur_req = "R12";
    obq(64'h1_0000_0010);
    // R11: request during control-word write uses old mapping
    cur_req = "R11";
    wr(12'h900, 32'h1);
    reg_we = 1; reg_addr = 12'h908; reg_wdata = 32'h0; ob_req = 1; ob_addr = 64'h1100;
    tick(); reg_we = 0; ob_req = 0;
    obq(64'h1100);
    // R2: out-of-range index and unknown offsets
    cur_req = "R2";
    wr(12'h900, 32'h5); wr(12'h90C, 32'hFFFF); rd(12'h90C); rd(12'h900);
    wr(12'h900, 32'h1); rd(12'h90C);
    wr(12'h920, 32'hDEAD); rd(12'h920);
    // random mix for R5 R6 R7 R8 R12
    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      int act;
      act = int'($urandom % 8);
      reg_we = 0;
      if (act < 5) begin
        reg_we = 1;
        case (act)
          0: begin reg_addr = 12'h900; reg_wdata = {$urandom % 2 == 0, 27'h0, 4'($urandom % 5)}; end
          1: begin reg_addr = 12'h90C; reg_wdata = ($urandom % 8) * 32'h100; end
          2: begin reg_addr = 12'h914; reg_wdata = ($urandom % 10) * 32'h100 + 32'hFF; end
          3: begin reg_addr = 12'h904 + 12'(($urandom % 2) * 4); reg_wdata = {$urandom % 2 == 0, 31'($urandom % 3)}; end
          default: begin reg_addr = 12'h918 + 12'(($urandom % 2) * 4); reg_wdata = $urandom; end
        endcase
      end else reg_addr = 12'h900 + 12'(($urandom % 9) * 4);
      ob_req = ($urandom % 2) == 1; ob_addr = {32'($urandom % 2), 32'($urandom % 32'hB00)};
      ib_req = ($urandom % 2) == 1; ib_addr = {32'($urandom % 2), 32'($urandom % 32'hB00)};
      tick();
    end
    reg_we = 0; ob_req = 0; ib_req = 0;
    tick();
    finish_run();
  end
endmodule